// File: doc/BRIEF.md
# Dead-Time Complementary PWM Output Stage

This block sits beside one duty-counting channel of a motor-drive timer and turns that channel's compare events into a pair of gate-drive pins with a programmable dead gap. Each time the duty channel reports a compare event, it also reports whether the carrier was counting up or down at that moment. The block uses each such event, and a channel start pulse, to launch a one-shot down-counter loaded from a dead-time register. When that counter runs out, it produces an internal dead-time event that carries the direction captured at launch.

The two outputs follow set/reset rules. One rule set applies to an output whose phase bit is 0 and the other to an output whose phase bit is 1. When a set and a reset fall on the same edge, the set wins. Choosing the phase bits decides whether the dead gap is added on the positive-logic side of the duty pulse or on the inverted side; normally the two phase bits are opposite. A level bit per pin then inverts the driven level, so either pin can be active-high or active-low. Dead-time events are internal only, because their number per carrier period varies from zero to three.

Top module: `dtpwm_out_stage`

## Requirements
- R1: A trigger is `start` or `duty_evt` high at a clock edge. It loads the dead-time counter with `dt_value` and starts it. While it runs with no new trigger, the counter decreases by one per clock.
- R2: A dead-time event occurs at the clock edge that is `dt_value`+1 edges after the trigger edge (one edge when `dt_value` is 0). The counter then idles and gives no further event until the next trigger.
- R3: A trigger arriving while the counter runs restarts it from `dt_value`, and the event that was pending is dropped.
- R4: An output whose phase bit is 0 is set by a dead-time event whose trigger was a duty event with `dir_down`=1. It is cleared by a duty event with `dir_down`=0.
- R5: An output whose phase bit is 1 is set by a duty event with `dir_down`=1. It is cleared by a dead-time event whose trigger was a duty event with `dir_down`=0.
- R6: When a set condition and a clear condition reach one output on the same edge, the output is set.
- R7: A dead-time event launched by `start` alone, with no duty event at that edge, changes neither output.
- R8: Each pin equals its internal state XOR its level bit (`lvl_pos` for `out_pos`, `lvl_neg` for `out_neg`), so level 1 makes that pin active-low.
- R9: Synchronous active-low reset clears both internal states and idles the counter, so each pin sits at its level bit.
- R10: The count direction used by a dead-time event is the one sampled at its trigger edge. Later changes of `dir_down` do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Channel start pulse, launches the dead-time counter |
| duty_evt | input | 1 | Duty compare event pulse from the paired duty channel |
| dir_down | input | 1 | Carrier direction at the duty event: 1 down, 0 up |
| dt_value | input | DT_W | Dead-time length register |
| phase_pos | input | 1 | Phase bit of the positive output |
| phase_neg | input | 1 | Phase bit of the complementary output |
| lvl_pos | input | 1 | Level inversion for `out_pos` |
| lvl_neg | input | 1 | Level inversion for `out_neg` |
| out_pos | output | 1 | Positive gate-drive pin |
| out_neg | output | 1 | Complementary gate-drive pin |

## Verification
Every combination of the two phase bits and two level bits is tried with dead-time lengths 0, 1, 3 and 6. Each combination runs under four stimulus patterns. Alternating down/up duty events spaced wider than the dead gap check the basic set/clear rules, and the direction input flips right after each event to show that the latched direction is used. Duty events spaced closer than the gap show the restart, with the pending event dropped. A duty event placed exactly on the edge where a dead-time event lands separates set-wins priority from clear-wins. A lone start pulse shows that a start-launched event leaves the pins alone. Directed checks count the exact edge on which each pin moves for a known gap length, and check the pin levels in reset.

// File: rtl/dtpwm_pkg.sv
// Package: shared types of the dead-time PWM output stage.
// Assumes: nothing beyond IEEE 1800-2017.
package dtpwm_pkg;

    // Origin of the trigger that launched the dead-time counter.
    typedef enum logic [1:0] {
        TAG_START = 2'd0,   // channel start, no duty event
        TAG_UP    = 2'd1,   // duty event while carrier counted up
        TAG_DOWN  = 2'd2    // duty event while carrier counted down
    } trig_tag_e;

endpackage

// File: rtl/dtpwm_dead_counter.sv
// Module: one-shot dead-time down-counter.
// Loads dt_value_i on any trigger (start or duty event), counts down one
// per clock, and raises dt_evt_o for one cycle when it sits at zero, then
// idles. The trigger origin and direction are latched at load time and
// presented with the event on dt_tag_o.
// Assumes: start_i and duty_evt_i are single-cycle pulses; a trigger while
// running restarts the count.
module dtpwm_dead_counter
    import dtpwm_pkg::*;
#(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            duty_evt_i,
    input  logic            dir_down_i,
    input  logic [DT_W-1:0] dt_value_i,
    output logic            dt_evt_o,
    output trig_tag_e       dt_tag_o
);

    localparam logic [DT_W-1:0] CNT_ZERO = '0;
    localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

    logic [DT_W-1:0] cnt_q;
    logic            run_q;
    trig_tag_e       tag_q;
    logic            trig;
    logic            hit;

    // Trigger and terminal-count decode.
    always_comb begin
        trig = start_i | duty_evt_i;
        hit  = run_q && (cnt_q == CNT_ZERO);
    end

    // Counter state: load on trigger, stop at zero, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_ZERO;
            run_q <= 1'b0;
            tag_q <= TAG_START;
        end else if (trig) begin
            cnt_q <= dt_value_i;
            run_q <= 1'b1;
            tag_q <= duty_evt_i ? (dir_down_i ? TAG_DOWN : TAG_UP) : TAG_START;
        end else if (hit) begin
            run_q <= 1'b0;
        end else if (run_q) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    // Event outputs.
    always_comb begin
        dt_evt_o = hit;
        dt_tag_o = tag_q;
    end

    // R1: a trigger loads the register value and starts the count.
    p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (run_q && cnt_q == $past(dt_value_i)));

    // R1: a running count with no trigger steps down by one.
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt_q != CNT_ZERO && !trig) |=> (run_q && cnt_q == $past(cnt_q) - CNT_ONE));

    // R2: after the event the counter idles.
    p_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !trig) |=> !run_q);

    // R2: an idle counter stays idle and produces no event without a trigger.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !trig) |=> (!run_q && !dt_evt_o));

    // R10: the latched tag holds while no trigger arrives.
    p_tag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !trig |=> $stable(tag_q));

endmodule

// File: rtl/dtpwm_phase_cell.sv
// Module: set/reset state of one output of the pair.
// With phase_i = 0 the dead gap delays the set (set by a down-launched
// dead-time event, cleared by an up duty event). With phase_i = 1 the gap
// delays the clear (set by a down duty event, cleared by an up-launched
// dead-time event). A coinciding set and clear resolves to set.
// Assumes: dt_tag_i is valid whenever dt_evt_i is high.
module dtpwm_phase_cell
    import dtpwm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      phase_i,
    input  logic      duty_evt_i,
    input  logic      dir_down_i,
    input  logic      dt_evt_i,
    input  trig_tag_e dt_tag_i,
    output logic      state_o
);

    logic set_c;
    logic clr_c;
    logic state_q;

    // Set/clear conditions selected by the phase bit.
    always_comb begin
        if (phase_i) begin
            set_c = duty_evt_i && dir_down_i;
            clr_c = dt_evt_i && (dt_tag_i == TAG_UP);
        end else begin
            set_c = dt_evt_i && (dt_tag_i == TAG_DOWN);
            clr_c = duty_evt_i && !dir_down_i;
        end
    end

    // Output state register, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= 1'b0;
        end else if (set_c) begin
            state_q <= 1'b1;
        end else if (clr_c) begin
            state_q <= 1'b0;
        end
    end

    // Drive the state out.
    always_comb state_o = state_q;

    // R6: any set condition leaves the output set, clear or not.
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_c |=> state_q);

    // R4: a lone clear condition clears the output.
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_c && !set_c) |=> !state_q);

    // R7: with neither condition the output holds.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_c && !clr_c) |=> $stable(state_q));

    // R9: reset leaves the state cleared.
    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> !state_q);

endmodule

// File: rtl/dtpwm_out_stage.sv
// Module: dead-time complementary PWM output stage (top).
// Runs one dead-time counter from the duty channel's events and drives two
// phase cells whose states are level-adjusted onto the output pins.
// Assumes: duty_evt and start are single-cycle pulses synchronous to clk;
// dir_down is valid whenever duty_evt is high.
module dtpwm_out_stage
    import dtpwm_pkg::*;
#(
    parameter int DT_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            duty_evt,
    input  logic            dir_down,
    input  logic [DT_W-1:0] dt_value,
    input  logic            phase_pos,
    input  logic            phase_neg,
    input  logic            lvl_pos,
    input  logic            lvl_neg,
    output logic            out_pos,
    output logic            out_neg
);

    localparam int N_OUT = 2;

    logic             dt_evt;
    trig_tag_e        dt_tag;
    logic [N_OUT-1:0] phase_sel;
    logic [N_OUT-1:0] lvl_sel;
    logic [N_OUT-1:0] st;
    logic [N_OUT-1:0] pin;

    // Gather per-output configuration; index 0 is positive, 1 complementary.
    always_comb begin
        phase_sel = {phase_neg, phase_pos};
        lvl_sel   = {lvl_neg, lvl_pos};
    end

    dtpwm_dead_counter #(
        .DT_W(DT_W)
    ) dead_cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .duty_evt_i (duty_evt),
        .dir_down_i (dir_down),
        .dt_value_i (dt_value),
        .dt_evt_o   (dt_evt),
        .dt_tag_o   (dt_tag)
    );

    for (genvar g = 0; g < N_OUT; g++) begin : g_cell
        dtpwm_phase_cell cell_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .phase_i    (phase_sel[g]),
            .duty_evt_i (duty_evt),
            .dir_down_i (dir_down),
            .dt_evt_i   (dt_evt),
            .dt_tag_i   (dt_tag),
            .state_o    (st[g])
        );
    end

    // Apply per-pin level inversion.
    always_comb begin
        pin     = st ^ lvl_sel;
        out_pos = pin[0];
        out_neg = pin[1];
    end

    // R9: one edge after reset both pins rest at their level bits.
    p_reset_pins_r9: assert property (@(posedge clk)
        !rst_n |=> (st == '0));

    // R8: a pin moves only when its cell state moves or its level bit moves.
    p_pin_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(st[0]) && $stable(lvl_pos)) |-> $stable(out_pos));

endmodule

// File: tb/dtpwm_out_stage_tb.sv
// Bench: sweeps phase bits, level bits and dead-time lengths over four
// stimulus patterns, against a cycle model built from the requirements,
// plus directed edge-count checks.
module dtpwm_out_stage_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DT_W       = 8;
    localparam int WATCHDOG   = 150000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            duty_evt = 1'b0;
    logic            dir_down = 1'b0;
    logic [DT_W-1:0] dt_value = '0;
    logic            phase_pos = 1'b0;
    logic            phase_neg = 1'b1;
    logic            lvl_pos = 1'b0;
    logic            lvl_neg = 1'b0;
    logic            out_pos;
    logic            out_neg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dtpwm_out_stage #(.DT_W(DT_W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .duty_evt  (duty_evt),
        .dir_down  (dir_down),
        .dt_value  (dt_value),
        .phase_pos (phase_pos),
        .phase_neg (phase_neg),
        .lvl_pos   (lvl_pos),
        .lvl_neg   (lvl_neg),
        .out_pos   (out_pos),
        .out_neg   (out_neg)
    );

    // Requirement model: tag 0 start, 1 up-launched, 2 down-launched.
    int m_cnt  = 0;
    bit m_run  = 0;
    int m_tag  = 0;
    bit m_st[2] = '{0, 0};

    always @(posedge clk) begin
        bit ev;
        bit ph;
        bit s;
        bit c;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_tag = 0;
            m_st[0] = 0; m_st[1] = 0;
        end else begin
            ev = m_run && (m_cnt == 0);
            for (int k = 0; k < 2; k++) begin
                ph = (k == 0) ? phase_pos : phase_neg;
                if (ph) begin
                    s = duty_evt && dir_down;
                    c = ev && (m_tag == 1);
                end else begin
                    s = ev && (m_tag == 2);
                    c = duty_evt && !dir_down;
                end
                if (s) m_st[k] = 1;
                else if (c) m_st[k] = 0;
            end
            if (start || duty_evt) begin
                m_cnt = int'(dt_value);
                m_run = 1;
                m_tag = duty_evt ? (dir_down ? 2 : 1) : 0;
            end else if (ev) begin
                m_run = 0;
            end else if (m_run) begin
                m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive pulses, pass the edge, compare at the falling edge.
    task automatic tick(input logic s, input logic d, input logic dn, input string lab);
        start = s; duty_evt = d; dir_down = dn;
        @(posedge clk);
        @(negedge clk);
        chk(out_pos, m_st[0] ^ lvl_pos, {lab, " out_pos"});
        chk(out_neg, m_st[1] ^ lvl_neg, {lab, " out_neg"});
        start = 1'b0; duty_evt = 1'b0;
    endtask

    task automatic idle(input int n, input string lab);
        for (int i = 0; i < n; i++) tick(1'b0, 1'b0, dir_down, lab);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        // R9: pins rest at their level bits in reset.
        lvl_pos = 1'b1; lvl_neg = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(out_pos, 1'b1, "R9 reset out_pos at level bit");
        chk(out_neg, 1'b0, "R9 reset out_neg at level bit");
        lvl_pos = 1'b0; lvl_neg = 1'b1;
        @(negedge clk);
        chk(out_pos, 1'b0, "R8 R9 reset out_pos follows level");
        chk(out_neg, 1'b1, "R8 R9 reset out_neg follows level");

        // Directed edge count, gap 3, phase_pos 0, phase_neg 1, active-high.
        lvl_pos = 1'b0; lvl_neg = 1'b0;
        phase_pos = 1'b0; phase_neg = 1'b1; dt_value = 8'd3;
        rst_n = 1'b1;
        @(negedge clk);
        tick(1'b0, 1'b1, 1'b1, "R5 down duty event");
        chk(out_neg, 1'b1, "R5 neg set on down duty edge");
        chk(out_pos, 1'b0, "R4 pos waits for gap");
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b0, 1'b0, "R1 counting");
            chk(out_pos, 1'b0, "R1 R2 pos low during gap");
        end
        tick(1'b0, 1'b0, 1'b0, "R2 gap end");
        chk(out_pos, 1'b1, "R2 R4 pos set at gap+1 edges");
        tick(1'b0, 1'b1, 1'b0, "R4 up duty event");
        chk(out_pos, 1'b0, "R4 pos cleared on up duty edge");
        chk(out_neg, 1'b1, "R5 neg held during gap");
        idle(3, "R5 gap");
        chk(out_neg, 1'b1, "R5 neg still set before gap end");
        tick(1'b0, 1'b0, 1'b1, "R10 dir flipped");
        chk(out_neg, 1'b0, "R5 R10 neg cleared by up-launched event");

        // Sweep all phase/level combinations and several gap lengths.
        for (int cfg = 0; cfg < 16; cfg++) begin
            for (int di = 0; di < 4; di++) begin
                int dv;
                dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? 3 : 6;
                phase_pos = cfg[0]; phase_neg = cfg[1];
                lvl_pos = cfg[2]; lvl_neg = cfg[3];
                dt_value = DT_W'(dv);
                do_reset();
                // Pattern A: wide alternating events, direction flips after.
                for (int k = 0; k < 4; k++) begin
                    bit dn;
                    dn = (k % 2 == 0);
                    tick(1'b0, 1'b1, dn, "R4 R5 R8 wide");
                    tick(1'b0, 1'b0, !dn, "R10 dir change");
                    idle(dv + 3, "R4 R5 R10 wide");
                end
                // Pattern B: retrigger inside the gap.
                if (dv >= 1) begin
                    tick(1'b0, 1'b1, 1'b1, "R3 first");
                    tick(1'b0, 1'b1, 1'b0, "R3 restart");
                    idle(dv + 3, "R3 after restart");
                    tick(1'b0, 1'b1, 1'b1, "R3 first b");
                    idle(dv - 1, "R3 gap part");
                    tick(1'b0, 1'b1, 1'b0, "R3 late restart");
                    idle(dv + 3, "R3 tail");
                end
                // Pattern C: duty event lands on the dead-time event edge.
                tick(1'b0, 1'b1, 1'b1, "R6 launch down");
                idle(dv, "R6 wait");
                tick(1'b0, 1'b1, 1'b0, "R6 coincide up");
                idle(dv, "R6 wait b");
                tick(1'b0, 1'b1, 1'b1, "R6 coincide down");
                idle(dv + 3, "R6 tail");
                // Pattern D: start alone after a known state.
                tick(1'b1, 1'b0, 1'b1, "R7 start only");
                idle(dv + 3, "R7 start event");
                tick(1'b0, 1'b1, 1'b0, "R7 up event");
                idle(1, "R7 mid");
                tick(1'b1, 1'b0, 1'b1, "R7 start restart");
                idle(dv + 3, "R7 start tail");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule